// File: doc/BRIEF.md
# Status Register and Write-Protect Guard

This block keeps the status/control byte of a serial EEPROM and decides, cycle by cycle, whether the array may be written at a given address and whether a pending status-register update may take effect. It takes strobes from a separate command decoder: write-enable and write-disable, a status byte that has been fully received, the start of the internal write cycle, and the end of an internal write cycle. It also takes the active-low write-protect pin, the target array address and the busy flag. It returns the status byte for readout and two permission signals.

The write-enable latch sits in the soft reset domain. The protect-enable bit and the two block-protect bits are the non-volatile bits. A separate power-on reset clears them, and the soft reset leaves them untouched. A status update is held in a pending state from the moment its data byte arrives until the internal cycle starts. If the hardware lock asserts in that window, the update is cancelled, and it stays cancelled even when the lock releases before the start. Block protection follows a two-bit code that selects none, the top quarter, the top half or the whole array.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_o` is laid out as bit 7 protect-enable, bits 6:4 always 0, bit 3 and bit 2 the block-protect code (bit 3 is its MSB), bit 1 the write-enable latch, and bit 0 a copy of `busy_i` (1 = internal write in progress).
- R2: After power-on reset, `status_o` reads 0x00 while `busy_i` is 0. A soft reset (`rst_ni` low) clears the write-enable latch and any pending status update, and keeps the protect-enable and block-protect bits.
- R3: A `wren_i` pulse sets the write-enable latch and a `wrdi_i` pulse clears it, visible one cycle later. When both arrive together, `wrdi_i` wins. Both are ignored while `busy_i` is 1.
- R4: A `wr_done_i` pulse clears the write-enable latch on the next cycle, even when it arrives together with `wren_i` or while busy.
- R5: With the latch at 0, `arr_wr_ok_o` is 0. With the latch at 1, `arr_wr_ok_o` is 0 exactly inside the protected range for the 13-bit address. Code 00 protects nothing, 01 protects 0x1800-0x1FFF, 10 protects 0x1000-0x1FFF, and 11 protects everything.
- R6: `arr_wr_ok_o` does not depend on the protect-enable bit or on `wp_ni`.
- R7: `sr_wr_ok_o` is 1 only when all of these hold: a status update is pending, it has not been cancelled, the latch is 1, and the hardware lock (protect-enable 1 and `wp_ni` 0) is not asserted.
- R8: `sr_start_i` while `sr_wr_ok_o` is 1 copies data bits 7, 3 and 2 into protect-enable and block-protect on the next cycle. The other data bits change nothing. The latch and the busy bit are never written through this path.
- R9: If the hardware lock asserts while an update is pending, that update is cancelled. A later `sr_start_i` leaves the bits unchanged, even after `wp_ni` returns high. With protect-enable at 0, `wp_ni` cancels nothing.
- R10: `sr_start_i` without permission, or with no update pending, leaves protect-enable and block-protect unchanged. A new `sr_load_i` is ignored while `busy_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, async; clears all bits |
| rst_ni | input | 1 | Soft reset, active low, async; volatile state only |
| busy_i | input | 1 | Internal write cycle in progress |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wr_done_i | input | 1 | Internal array/status write cycle completed |
| sr_load_i | input | 1 | Status data byte fully received |
| sr_wdata_i | input | 8 | Received status data byte |
| sr_start_i | input | 1 | Internal cycle starts (chip select released) |
| wp_ni | input | 1 | Write-protect pin, active low |
| arr_addr_i | input | AW | Target array address |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write permitted at `arr_addr_i` |
| sr_wr_ok_o | output | 1 | Pending status update may be committed |

## Verification
The in-line properties check these on every cycle: the write-enable latch follows its set and clear strobes, and the latch freezes while busy. An array write is never allowed with the latch low or under full protection, and the quarter-protect boundary holds. Non-volatile bits change only on a permitted commit, and then take the held data. A cancelled update never shows as permitted. The directed scenarios are needed for the rest: the sticky cancel when the pin drops and returns mid-transaction, the masking of data bits 6:4 and 1:0, the boundary addresses of each protect code, and the survival of the non-volatile bits across a soft reset.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  localparam int unsigned SR_BUSY = 0;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_BP0  = 2;
  localparam int unsigned SR_BP1  = 3;
  localparam int unsigned SR_WPEN = 7;
endpackage

// File: rtl/esg_prot_dec.sv
module esg_prot_dec #(
  parameter int unsigned AW = 13
) (
  input  logic [1:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  import esg_pkg::*;

  localparam int unsigned MSB = AW - 1;

  always_comb begin
    unique case (prot_e'(bp_i))
      PROT_NONE: hit_o = 1'b0;
      PROT_QTR:  hit_o = addr_i[MSB] & addr_i[MSB-1];
      PROT_HALF: hit_o = addr_i[MSB];
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/esg_wel.sv
module esg_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic done_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wel_q <= 1'b0;
    else if (done_i)       wel_q <= 1'b0;
    else if (!busy_i) begin
      if (wrdi_i)          wel_q <= 1'b0;
      else if (wren_i)     wel_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;

  assert_wel_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wren_i && !wrdi_i && !done_i) |=> wel_q);
  assert_wel_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> $stable(wel_q));
  assert_wel_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wel_q);
endmodule

// File: rtl/esg_nv.sv
module esg_nv (
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       load_i,
  input  logic [2:0] wdata_i,   // {wpen, bp1, bp0}
  input  logic       start_i,
  input  logic       wp_ni,
  input  logic       wel_i,
  output logic       wpen_o,
  output logic [1:0] bp_o,
  output logic       ok_o
);
  logic       wpen_q;
  logic [1:0] bp_q;
  logic       pend_q, abort_q;
  logic [2:0] wd_q;
  logic       hw_lock, commit;

  assign hw_lock = wpen_q & ~wp_ni;
  assign ok_o    = pend_q & ~abort_q & wel_i & ~hw_lock;
  assign commit  = start_i & ok_o;

  // non-volatile bits: power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (commit) begin
      wpen_q <= wd_q[2];
      bp_q   <= wd_q[1:0];
    end
  end

  // pending update; cancel is sticky until the cycle start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      wd_q    <= 3'b000;
    end else if (start_i) begin
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else if (load_i && !busy_i) begin
      pend_q  <= 1'b1;
      abort_q <= hw_lock;
      wd_q    <= wdata_i;
    end else if (pend_q && hw_lock) begin
      abort_q <= 1'b1;
    end
  end

  assign wpen_o = wpen_q;
  assign bp_o   = bp_q;

  assert_nv_hold_R10: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !commit |=> $stable({wpen_q, bp_q}));
  assert_nv_commit_R8: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    commit |=> ({wpen_q, bp_q} == $past(wd_q)));
  assert_abort_blocks_R9: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    abort_q |-> !ok_o);
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard #(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          wren_i,
  input  logic          wrdi_i,
  input  logic          wr_done_i,
  input  logic          sr_load_i,
  input  logic [7:0]    sr_wdata_i,
  input  logic          sr_start_i,
  input  logic          wp_ni,
  input  logic [AW-1:0] arr_addr_i,
  output logic [7:0]    status_o,
  output logic          arr_wr_ok_o,
  output logic          sr_wr_ok_o
);
  import esg_pkg::*;

  logic       soft_rst_n;
  logic       wel, wpen, prot_hit;
  logic [1:0] bp;
  logic       unused_wdata;

  assign soft_rst_n   = rst_ni & por_ni;
  assign unused_wdata = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

  esg_wel u_wel (
    .clk_i  (clk_i),
    .rst_ni (soft_rst_n),
    .busy_i (busy_i),
    .wren_i (wren_i),
    .wrdi_i (wrdi_i),
    .done_i (wr_done_i),
    .wel_o  (wel)
  );

  esg_nv u_nv (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .rst_ni  (soft_rst_n),
    .busy_i  (busy_i),
    .load_i  (sr_load_i),
    .wdata_i ({sr_wdata_i[SR_WPEN], sr_wdata_i[SR_BP1], sr_wdata_i[SR_BP0]}),
    .start_i (sr_start_i),
    .wp_ni   (wp_ni),
    .wel_i   (wel),
    .wpen_o  (wpen),
    .bp_o    (bp),
    .ok_o    (sr_wr_ok_o)
  );

  esg_prot_dec #(.AW(AW)) u_dec (
    .bp_i   (bp),
    .addr_i (arr_addr_i),
    .hit_o  (prot_hit)
  );

  assign arr_wr_ok_o = wel & ~prot_hit;

  always_comb begin
    status_o          = 8'h00;
    status_o[SR_WPEN] = wpen;
    status_o[SR_BP1]  = bp[1];
    status_o[SR_BP0]  = bp[0];
    status_o[SR_WEL]  = wel;
    status_o[SR_BUSY] = busy_i;
  end

  assert_no_wel_R5: assert property (@(posedge clk_i) disable iff (!soft_rst_n)
    !status_o[SR_WEL] |-> (!arr_wr_ok_o && !sr_wr_ok_o));
  assert_full_prot_R5: assert property (@(posedge clk_i) disable iff (!soft_rst_n)
    (status_o[SR_BP1:SR_BP0] == 2'b11) |-> !arr_wr_ok_o);
  assert_qtr_open_R5: assert property (@(posedge clk_i) disable iff (!soft_rst_n)
    (status_o[SR_BP1:SR_BP0] == 2'b01 && status_o[SR_WEL] &&
     arr_addr_i[AW-1:AW-2] != 2'b11) |-> arr_wr_ok_o);
  assert_hw_lock_R7: assert property (@(posedge clk_i) disable iff (!soft_rst_n)
    (status_o[SR_WPEN] && !wp_ni) |-> !sr_wr_ok_o);
endmodule

// File: tb/eeprom_status_guard_tb.sv
`timescale 1ns/1ps
module eeprom_status_guard_tb;
  logic        clk_i = 1'b0;
  logic        por_ni, rst_ni, busy_i, wren_i, wrdi_i, wr_done_i;
  logic        sr_load_i, sr_start_i, wp_ni;
  logic [7:0]  sr_wdata_i;
  logic [12:0] arr_addr_i;
  logic [7:0]  status_o;
  logic        arr_wr_ok_o, sr_wr_ok_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  eeprom_status_guard #(.AW(13)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask
  task automatic p_wren(); wren_i = 1; cyc(); wren_i = 0; endtask
  task automatic p_wrdi(); wrdi_i = 1; cyc(); wrdi_i = 0; endtask
  task automatic p_done(); wr_done_i = 1; cyc(); wr_done_i = 0; endtask
  task automatic p_load(input logic [7:0] d);
    sr_wdata_i = d; sr_load_i = 1; cyc(); sr_load_i = 0;
  endtask
  task automatic p_start(); sr_start_i = 1; cyc(); sr_start_i = 0; endtask

  // full status write transaction, then cycle completion
  task automatic sr_write(input logic [7:0] d);
    p_wren(); p_load(d); p_start(); p_done();
  endtask

  task automatic t_reset();
    por_ni = 0; rst_ni = 0; busy_i = 0; wren_i = 0; wrdi_i = 0; wr_done_i = 0;
    sr_load_i = 0; sr_start_i = 0; wp_ni = 1; sr_wdata_i = 0; arr_addr_i = 0;
    cyc(); cyc(); por_ni = 1; rst_ni = 1; cyc();
    chk("R2 reset status", status_o, 8'h00);
    busy_i = 1; #1;
    chk("R1 busy bit", status_o, 8'h01);
    busy_i = 0; #1;
  endtask

  task automatic t_wel();
    p_wren();
    chk("R3 wren sets", status_o, 8'h02);
    p_wrdi();
    chk("R3 wrdi clears", status_o, 8'h00);
    p_wren(); wren_i = 1; wrdi_i = 1; cyc(); wren_i = 0; wrdi_i = 0;
    chk("R3 wrdi wins", status_o, 8'h00);
    busy_i = 1; p_wren();
    chk("R3 wren ignored busy", status_o, 8'h01);
    busy_i = 0; p_wren(); busy_i = 1; p_wrdi();
    chk("R3 wrdi ignored busy", status_o, 8'h03);
    p_done();
    chk("R4 done clears busy", status_o, 8'h01);
    busy_i = 0; wren_i = 1; wr_done_i = 1; cyc(); wren_i = 0; wr_done_i = 0;
    chk("R4 done beats wren", status_o, 8'h00);
  endtask

  task automatic arr_chk(input string req, input logic [12:0] a, input logic exp);
    arr_addr_i = a; #1; chk(req, arr_wr_ok_o, exp);
  endtask

  task automatic t_protect();
    arr_chk("R5 wel0 denies", 13'h0000, 0);
    p_wren();
    arr_chk("R5 none top", 13'h1FFF, 1);
    sr_write(8'h04); p_wren();
    chk("R8 bp01 status", status_o, 8'h06);
    arr_chk("R5 qtr below", 13'h17FF, 1);
    arr_chk("R5 qtr edge", 13'h1800, 0);
    arr_chk("R5 qtr top", 13'h1FFF, 0);
    sr_write(8'h08); p_wren();
    arr_chk("R5 half below", 13'h0FFF, 1);
    arr_chk("R5 half edge", 13'h1000, 0);
    sr_write(8'h0C); p_wren();
    arr_chk("R5 full low", 13'h0000, 0);
    sr_write(8'h84); p_wren();
    chk("R8 wpen set", status_o, 8'h86);
    wp_ni = 0;
    arr_chk("R6 wp low open", 13'h0000, 1);
    arr_chk("R6 wp low prot", 13'h1800, 0);
    wp_ni = 1;
    p_wrdi();
  endtask

  task automatic t_sr_gate();
    // wpen=1, bp=01 now
    wp_ni = 0; p_wren(); p_load(8'h00);
    chk("R7 hw lock denies", sr_wr_ok_o, 0);
    p_start(); p_done();
    chk("R10 locked no change", status_o, 8'h84);
    wp_ni = 1; p_load(8'h00);
    chk("R7 wel0 denies", sr_wr_ok_o, 0);
    p_start();
    chk("R10 wel0 no change", status_o, 8'h84);
    p_wren();
    chk("R7 no pending", sr_wr_ok_o, 0);
    p_start();
    chk("R10 start no pend", status_o, 8'h86);
    p_load(8'h00);
    chk("R7 allowed", sr_wr_ok_o, 1);
    p_start();
    chk("R8 clear wpen bp", status_o, 8'h02);
    p_done();
  endtask

  task automatic t_mask();
    p_wren(); p_load(8'h73); p_start();
    chk("R8 masked bits", status_o, 8'h02);
    p_done();
    chk("R8 after done", status_o, 8'h00);
    busy_i = 1; p_load(8'h8C); busy_i = 0; p_wren();
    chk("R10 load ignored busy", sr_wr_ok_o, 0);
    p_start();
    chk("R10 load busy no change", status_o, 8'h02);
    p_wrdi();
  endtask

  task automatic t_abort();
    sr_write(8'h80);
    chk("R8 wpen only", status_o, 8'h80);
    p_wren(); p_load(8'h0C);
    chk("R9 pre abort ok", sr_wr_ok_o, 1);
    wp_ni = 0; cyc(); wp_ni = 1; #1;
    chk("R9 cancelled", sr_wr_ok_o, 0);
    p_start();
    chk("R9 no commit", status_o, 8'h82);
    p_done();
    sr_write(8'h00);
    chk("R9 wpen cleared", status_o, 8'h00);
    p_wren(); p_load(8'h08);
    wp_ni = 0; cyc(); wp_ni = 1; p_start();
    chk("R9 wpen0 no cancel", status_o, 8'h0A);
    p_done();
  endtask

  task automatic t_soft();
    sr_write(8'h8C); p_wren();
    chk("R2 pre soft", status_o, 8'h8E);
    rst_ni = 0; cyc(); rst_ni = 1; cyc();
    chk("R2 soft keeps nv", status_o, 8'h8C);
    por_ni = 0; cyc(); por_ni = 1; cyc();
    chk("R2 por clears", status_o, 8'h00);
  endtask

  initial begin
    t_reset();
    t_wel();
    t_protect();
    t_sr_gate();
    t_mask();
    t_abort();
    t_soft();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(posedge clk_i);
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule